// File: doc/BRIEF.md
# Headphone Presence and Load-Check Mode Sequencer

This block decides how a ground-referenced stereo headphone amplifier is powered and configured. It filters the headphone-presence input, applies the software power bit, wakes the negative-supply charge pump, and then asks an analog load checker to classify each output. From the result it chooses the final arrangement: both amplifiers on, a mono arrangement where the left amplifier carries the mixed signal, or both amplifiers off.

The analog checker is seen only through two comparator bits per channel: "short" (below about 3 ohm) and "ok" (above about 9 ohm). When neither bit is set the load is in the undefined band. Every timed interval counts pulses of a clock-enable `tick`, so the same logic serves any tick rate. The debounce, wake-up and probe lengths are parameters. A full-scale part might use a 10 kHz tick with 2000, 3 and 2 ticks for 200 ms, 300 us and the probe window.

Top module: `hpdet_ctrl`

## Requirements
- R1: With `cfg_run` low, the pump, both amplifiers, the mix select, the probe request and `mute_out` are all low, whatever the presence input does. With `cfg_run` high and the filtered presence low (standby), the pump and amplifiers are also low. Reset leaves every output low.
- R2: A change on `hp_sense` takes effect only after it has held its new level for `DEB_TICKS` consecutive ticks. A pulse shorter than that is ignored. The first resulting output change appears one clock after the filtered level flips.
- R3: On entry to power-up, `pump_en` rises first. No amplifier and no probe request is enabled until `WAKE_TICKS` ticks have passed.
- R4: When load checking is enabled, a probe follows each of three events: headphone insertion while `cfg_run` is high, `cfg_run` rising while a headphone is already present, and `thermal_trip` falling while a headphone is present.
- R5: `probe_req` stays high for exactly `PROBE_TICKS` ticks. The load bits are captured only on the last tick of that window. Values present earlier in the window, or after it, have no effect.
- R6: A channel classified "ok" or undefined keeps its amplifier enabled.
- R7: A captured right-channel short forces mono: the left amplifier is on, the right amplifier is off and `mono_mix` is high.
- R8: A captured left-channel short turns both amplifiers off and holds `mono_mix` low, whatever the right channel shows.
- R9: With `cfg_autodetect` low, no probe is issued, the load bits are ignored, and `cfg_stereo` alone selects stereo (1) or mono (0).
- R10: In mono the right amplifier is off, the left is on and `mono_mix` is high. The mix select attenuates the left-plus-right sum by 6 dB.
- R11: Whenever `cfg_run` is high, `mute_out` follows `cfg_mute` one-for-one, and changing it does not disturb the amplifiers or the sequence.
- R12: While `thermal_trip` is high, the amplifiers and the pump are off from the next clock on. When the trip clears, the wake-up and probe sequence restarts.
- R13: When `tick` is low, every interval counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable for the interval counters |
| hp_sense | input | 1 | Headphone presence, synchronous to clk, 1 = inserted |
| cfg_run | input | 1 | 1 = normal operation, 0 = micro-power shutdown |
| cfg_autodetect | input | 1 | 1 = probe loads and apply short handling |
| cfg_mute | input | 1 | Mute request |
| cfg_stereo | input | 1 | 1 = stereo, 0 = mono |
| thermal_trip | input | 1 | Over-temperature flag |
| left_short | input | 1 | Left load below short threshold |
| left_ok | input | 1 | Left load above valid threshold |
| right_short | input | 1 | Right load below short threshold |
| right_ok | input | 1 | Right load above valid threshold |
| amp_left_en | output | 1 | Left amplifier enable |
| amp_right_en | output | 1 | Right amplifier enable |
| mono_mix | output | 1 | Route the attenuated L+R sum to the left amplifier |
| pump_en | output | 1 | Charge-pump enable |
| mute_out | output | 1 | Mute to the audio path |
| probe_req | output | 1 | Request to the analog load checker |

## Verification
The hardest case to reach is a load result that changes inside the probe window. The capture must take the value on the last tick and ignore every earlier one. The stimulus first observes `probe_req` rising, then counts `PROBE_TICKS-1` clocks with a short applied, and swaps to a good load just before the final edge. A second hard case is thermal recovery followed by a fresh probe that now sees a short. This is reached by tripping and clearing the flag while the channel is active, with the load already changed.

// File: rtl/hpdet_pkg.sv
`timescale 1ns/1ps
package hpdet_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_STBY  = 3'd1,
    ST_WAKE  = 3'd2,
    ST_PROBE = 3'd3,
    ST_RUN   = 3'd4,
    ST_HOT   = 3'd5
  } hp_state_e;

  typedef struct packed {
    logic left_on;
    logic right_on;
    logic mix;
  } route_t;

  // Final amplifier arrangement from config and captured shorts
  function automatic route_t pick_route(input logic auto_on, input logic stereo,
                                        input logic lshort, input logic rshort);
    route_t r;
    logic kill, mono;
    kill = auto_on & lshort;
    mono = ~stereo | (auto_on & rshort);
    r.left_on  = ~kill;
    r.right_on = ~kill & ~mono;
    r.mix      = ~kill & mono;
    return r;
  endfunction

  function automatic logic pump_state(input hp_state_e s);
    return (s == ST_WAKE) || (s == ST_PROBE) || (s == ST_RUN);
  endfunction

endpackage

// File: rtl/hpdet_debounce.sv
`timescale 1ns/1ps
module hpdet_debounce #(
  parameter int DEB_TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(DEB_TICKS + 1);

  logic [CW-1:0] cnt;
  logic          differs;

  assign differs = raw ^ level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (!differs) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == CW'(DEB_TICKS - 1)) begin
        level <= raw;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hpdet_seq.sv
`timescale 1ns/1ps
module hpdet_seq
  import hpdet_pkg::*;
#(
  parameter int WAKE_TICKS  = 3,
  parameter int PROBE_TICKS = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      present,
  input  logic      cfg_run,
  input  logic      cfg_autodetect,
  input  logic      thermal_trip,
  input  logic      left_short,
  input  logic      right_short,
  output hp_state_e state,
  output logic      lshort_q,
  output logic      rshort_q,
  output logic      wake_done,
  output logic      probe_done
);
  localparam int MAXT = (WAKE_TICKS > PROBE_TICKS) ? WAKE_TICKS : PROBE_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  hp_state_e     nxt;
  logic [CW-1:0] cnt;
  logic          entering_wake;

  assign wake_done  = (state == ST_WAKE)  && tick && (cnt == CW'(WAKE_TICKS - 1));
  assign probe_done = (state == ST_PROBE) && tick && (cnt == CW'(PROBE_TICKS - 1));
  assign entering_wake = (nxt == ST_WAKE) && (state != ST_WAKE);

  always_comb begin
    nxt = state;
    if (!cfg_run)          nxt = ST_OFF;
    else if (thermal_trip) nxt = ST_HOT;
    else if (!present)     nxt = ST_STBY;
    else begin
      case (state)
        ST_OFF, ST_STBY, ST_HOT: nxt = ST_WAKE;
        ST_WAKE:  if (wake_done)  nxt = cfg_autodetect ? ST_PROBE : ST_RUN;
        ST_PROBE: if (probe_done) nxt = ST_RUN;
        default:  nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OFF;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)
        cnt <= '0;
      else if (tick && (state == ST_WAKE || state == ST_PROBE))
        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lshort_q <= 1'b0;
      rshort_q <= 1'b0;
    end else if (entering_wake) begin
      lshort_q <= 1'b0;
      rshort_q <= 1'b0;
    end else if (probe_done) begin
      lshort_q <= left_short;
      rshort_q <= right_short;
    end
  end
endmodule

// File: rtl/hpdet_route.sv
`timescale 1ns/1ps
module hpdet_route
  import hpdet_pkg::*;
(
  input  hp_state_e state,
  input  logic      cfg_autodetect,
  input  logic      cfg_stereo,
  input  logic      cfg_mute,
  input  logic      lshort_q,
  input  logic      rshort_q,
  output logic      amp_left_en,
  output logic      amp_right_en,
  output logic      mono_mix,
  output logic      pump_en,
  output logic      mute_out,
  output logic      probe_req
);
  route_t rt;
  logic   active;

  always_comb begin
    rt           = pick_route(cfg_autodetect, cfg_stereo, lshort_q, rshort_q);
    active       = (state == ST_RUN);
    amp_left_en  = active & rt.left_on;
    amp_right_en = active & rt.right_on;
    mono_mix     = active & rt.mix;
    pump_en      = pump_state(state);
    probe_req    = (state == ST_PROBE);
    mute_out     = cfg_mute & (state != ST_OFF);
  end
endmodule

// File: rtl/hpdet_ctrl.sv
`timescale 1ns/1ps
module hpdet_ctrl
  import hpdet_pkg::*;
#(
  parameter int DEB_TICKS   = 2000,
  parameter int WAKE_TICKS  = 3,
  parameter int PROBE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hp_sense,
  input  logic cfg_run,
  input  logic cfg_autodetect,
  input  logic cfg_mute,
  input  logic cfg_stereo,
  input  logic thermal_trip,
  input  logic left_short,
  input  logic left_ok,
  input  logic right_short,
  input  logic right_ok,
  output logic amp_left_en,
  output logic amp_right_en,
  output logic mono_mix,
  output logic pump_en,
  output logic mute_out,
  output logic probe_req
);
  hp_state_e state;
  logic      present, lshort_q, rshort_q, wake_done, probe_done;
  logic      ok_unused;

  // "ok" and "undefined" classify alike: only the short bit matters
  assign ok_unused = left_ok ^ right_ok;

  hpdet_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(hp_sense), .level(present)
  );

  hpdet_seq #(.WAKE_TICKS(WAKE_TICKS), .PROBE_TICKS(PROBE_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .present(present),
    .cfg_run(cfg_run), .cfg_autodetect(cfg_autodetect),
    .thermal_trip(thermal_trip), .left_short(left_short),
    .right_short(right_short), .state(state), .lshort_q(lshort_q),
    .rshort_q(rshort_q), .wake_done(wake_done), .probe_done(probe_done)
  );

  hpdet_route u_route (
    .state(state), .cfg_autodetect(cfg_autodetect), .cfg_stereo(cfg_stereo),
    .cfg_mute(cfg_mute), .lshort_q(lshort_q), .rshort_q(rshort_q),
    .amp_left_en(amp_left_en), .amp_right_en(amp_right_en),
    .mono_mix(mono_mix), .pump_en(pump_en), .mute_out(mute_out),
    .probe_req(probe_req)
  );
endmodule

// File: rtl/hpdet_ctrl_chk.sv
`timescale 1ns/1ps
module hpdet_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_run,
  input logic thermal_trip,
  input logic amp_left_en,
  input logic amp_right_en,
  input logic mono_mix,
  input logic pump_en,
  input logic mute_out,
  input logic probe_req,
  input logic wake_done,
  input logic probe_done
);
  // R1
  shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_run |=> !pump_en && !amp_left_en && !amp_right_en && !mute_out && !probe_req);

  // R3
  amp_needs_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_left_en || amp_right_en) |-> pump_en);

  // R3
  pump_before_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amp_left_en) |-> $past(pump_en));

  // R3
  wake_end_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_done && cfg_run && !thermal_trip) |=> pump_en);

  // R5
  probe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req |-> !amp_left_en && !amp_right_en);

  // R5
  probe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_done |=> !probe_req);

  // R10
  right_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    amp_right_en |-> amp_left_en && !mono_mix);

  // R12
  thermal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_trip |=> !amp_left_en && !amp_right_en && !pump_en);
endmodule

bind hpdet_ctrl hpdet_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .thermal_trip(thermal_trip),
  .amp_left_en(amp_left_en), .amp_right_en(amp_right_en), .mono_mix(mono_mix),
  .pump_en(pump_en), .mute_out(mute_out), .probe_req(probe_req),
  .wake_done(wake_done), .probe_done(probe_done)
);

// File: tb/hpdet_ctrl_test.sv
`timescale 1ns/1ps
module hpdet_ctrl_test;
  localparam int DEB = 8, WAKE = 4, PROBE = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, hp_sense = 1'b0;
  logic cfg_run = 1'b0, cfg_autodetect = 1'b0, cfg_mute = 1'b0, cfg_stereo = 1'b1;
  logic thermal_trip = 1'b0;
  logic left_short = 1'b0, left_ok = 1'b1, right_short = 1'b0, right_ok = 1'b1;
  logic amp_left_en, amp_right_en, mono_mix, pump_en, mute_out, probe_req;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  hpdet_ctrl #(.DEB_TICKS(DEB), .WAKE_TICKS(WAKE), .PROBE_TICKS(PROBE)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hp_sense(hp_sense),
    .cfg_run(cfg_run), .cfg_autodetect(cfg_autodetect), .cfg_mute(cfg_mute),
    .cfg_stereo(cfg_stereo), .thermal_trip(thermal_trip),
    .left_short(left_short), .left_ok(left_ok), .right_short(right_short),
    .right_ok(right_ok), .amp_left_en(amp_left_en), .amp_right_en(amp_right_en),
    .mono_mix(mono_mix), .pump_en(pump_en), .mute_out(mute_out),
    .probe_req(probe_req)
  );

  // {auto, stereo, lcode[1:0], rcode[1:0], exp_left, exp_right, exp_mix}
  // load code: 0 undefined, 1 ok, 2 short
  localparam logic [8:0] VEC [0:8] = '{
    9'b1_1_01_01_110, 9'b1_1_01_10_101, 9'b1_1_10_01_000,
    9'b1_1_10_10_000, 9'b1_1_00_00_110, 9'b1_0_01_01_101,
    9'b0_1_10_10_110, 9'b0_0_01_01_101, 9'b1_1_01_00_110
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_loads(input logic [1:0] lc, input logic [1:0] rc);
    left_short = (lc == 2'd2); left_ok = (lc == 2'd1);
    right_short = (rc == 2'd2); right_ok = (rc == 2'd1);
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; hp_sense = 1'b0; thermal_trip = 1'b0; tick = 1'b1;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    cyc(150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1 reset outputs",
          {amp_left_en, amp_right_en, mono_mix, pump_en, mute_out, probe_req}, 0);

    // vector table: R6 R7 R8 R9 R10
    for (int i = 0; i < 9; i++) begin
      string tag;
      reset_dut();
      cfg_run = 1'b1; cfg_autodetect = VEC[i][8]; cfg_stereo = VEC[i][7];
      set_loads(VEC[i][6:5], VEC[i][4:3]);
      hp_sense = 1'b1;
      cyc(DEB + 1 + WAKE + PROBE + 1);
      if (!VEC[i][8]) tag = "R9";
      else if (VEC[i][6:5] == 2'd2) tag = "R8";
      else if (VEC[i][4:3] == 2'd2) tag = "R7";
      else if (!VEC[i][7]) tag = "R10";
      else tag = "R6";
      check({tag, " left"}, amp_left_en, VEC[i][2]);
      check({tag, " right"}, amp_right_en, VEC[i][1]);
      check({tag, " mix"}, mono_mix, VEC[i][0]);
    end

    // R2 glitch rejection and debounce boundary, R3 wake, R4 insertion, R5 window
    reset_dut();
    cfg_run = 1'b1; cfg_autodetect = 1'b1; cfg_stereo = 1'b1; set_loads(2'd1, 2'd1);
    hp_sense = 1'b1; cyc(DEB - 1); hp_sense = 1'b0; cyc(DEB + 4);
    check("R2 short pulse ignored", pump_en, 0);
    hp_sense = 1'b1; cyc(DEB);
    check("R2 not yet acted on", pump_en, 0);
    cyc(1);
    check("R2 acted on", pump_en, 1);
    check("R3 amp waits for pump", amp_left_en, 0);
    cyc(WAKE - 1);
    check("R3 no probe during wake", probe_req, 0);
    cyc(1);
    check("R4 probe after insertion", probe_req, 1);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      if (probe_req) n++;
      cyc(1);
    end
    check("R5 probe window length", n, PROBE);
    check("R6 stereo active", amp_right_en, 1);

    // R1 standby after removal
    hp_sense = 1'b0; cyc(DEB);
    check("R2 removal filtered", amp_left_en, 1);
    cyc(1);
    check("R1 standby pump", pump_en, 0);
    check("R1 standby amp", amp_left_en, 0);

    // R5 capture only on the last tick
    set_loads(2'd2, 2'd1); hp_sense = 1'b1;
    cyc(DEB + 1 + WAKE);
    check("R5 window open", probe_req, 1);
    cyc(PROBE - 1);
    set_loads(2'd1, 2'd1);
    cyc(1);
    check("R5 early short ignored", amp_left_en, 1);
    set_loads(2'd2, 2'd1); cyc(3);
    check("R5 late short ignored", amp_left_en, 1);

    // R11 mute
    cfg_mute = 1'b1; cyc(1);
    check("R11 mute follows", mute_out, 1);
    check("R11 amps undisturbed", amp_left_en, 1);
    cfg_mute = 1'b0; cyc(1);
    check("R11 unmute", mute_out, 0);

    // R12 thermal, R4 re-probe after recovery
    thermal_trip = 1'b1; cyc(1);
    check("R12 amps off", amp_left_en, 0);
    check("R12 pump off", pump_en, 0);
    thermal_trip = 1'b0; cyc(1);
    check("R12 rewake", pump_en, 1);
    cyc(WAKE);
    check("R4 probe after thermal", probe_req, 1);
    cyc(PROBE);
    check("R8 reprobe sees left short", amp_left_en, 0);

    // R1 shutdown, R4 power-up with headphone present
    cfg_mute = 1'b1; cfg_run = 1'b0; cyc(1);
    check("R1 shutdown pump", pump_en, 0);
    check("R1 shutdown mute", mute_out, 0);
    cfg_mute = 1'b0; set_loads(2'd1, 2'd1); cfg_run = 1'b1; cyc(1);
    check("R3 pump on power-up", pump_en, 1);
    cyc(WAKE);
    check("R4 probe after power-up", probe_req, 1);
    cyc(PROBE);
    check("R6 both on after power-up", {amp_left_en, amp_right_en}, 3);

    // R13 tick gating
    cfg_run = 1'b0; cyc(1); cfg_run = 1'b1; cyc(1);
    tick = 1'b0; cyc(WAKE + 6);
    check("R13 wake held", probe_req, 0);
    check("R13 pump held", pump_en, 1);
    tick = 1'b1; cyc(WAKE);
    check("R13 wake resumes", probe_req, 1);

    // R9 no probe when checking disabled
    reset_dut();
    cfg_autodetect = 1'b0; cfg_stereo = 1'b1; set_loads(2'd2, 2'd2); hp_sense = 1'b1;
    n = 0;
    for (int k = 0; k < DEB + WAKE + PROBE + 6; k++) begin
      if (probe_req) n++;
      cyc(1);
    end
    check("R9 no probe", n, 0);
    check("R9 stereo despite shorts", amp_right_en, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule